// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Register

This block turns a serial bit stream into a parallel byte. Bits enter a shift stage one per rising edge of a shift strobe. A separate latch strobe copies the whole shift stage into a holding register, and the holding register drives the parallel outputs. The parallel word therefore changes only when the latch strobe rises, however many bits are shifted in between.

The last shift stage is brought out as a cascade bit. Feeding it into the serial input of another copy builds a longer chain. An active-low clear empties the shift stage. An active-low output enable lets the parallel outputs float.

Both strobes, the clear and the serial bit come from outside the system clock domain. Each passes through a synchronizer and an edge detector, so only the system clock drives the internal flops.

Top module: `serial_latch_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets both the shift stage and the holding register to zero. After reset, `parData` is 0 and `cascadeOut` is 0.
- R2: Each shift action moves the serial bit into stage 0 and moves every stage i into stage i+1. `cascadeOut` is the top stage. A byte shifted in most significant bit first therefore sits in the shift stage in its own bit order. When two blocks are chained, the downstream block receives the bytes that leave the upstream block.
- R3: Each rising edge of a strobe causes exactly one action. A strobe that stays high causes nothing further.
- R4: While `clearN` is low, the shift stage and `cascadeOut` go to zero. The clear wins over a shift that happens in the same cycle.
- R5: The holding register changes only on a latch action. Shifting and clearing leave `parData` unchanged.
- R6: When both strobes rise together, the holding register takes the shift-stage contents from before that shift, so it stays one shift behind.
- R7: While `oeN` is high, `parDriveEn` is all zeros and every bit of `parPins` is high impedance. While `oeN` is low, `parDriveEn` is all ones and `parPins` equals `parData`.
- R8: A strobe rise that is driven between clock edges takes effect at the third rising clock edge after it. The first two edges change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data bit |
| shiftStrb | input | 1 | Shift strobe; acts on its rising edge |
| latchStrb | input | 1 | Latch strobe; acts on its rising edge |
| clearN | input | 1 | Clear for the shift stage, active low |
| oeN | input | 1 | Output enable, active low |
| parData | output | WIDTH | Holding register contents |
| parDriveEn | output | WIDTH | Per-bit drive enable for the pins |
| parPins | output | WIDTH | Tri-state parallel outputs |
| cascadeOut | output | 1 | Top shift stage, for chaining |

## Verification
The bench builds two copies with the default `WIDTH` of 8 and `SYNC_STAGES` of 2, and chains the cascade bit of the first copy into the second.

With this chain, each byte taken from the table must show up in the downstream copy exactly one latch later. With the two-stage synchronizer, the three-edge latency can be checked cycle by cycle.

The directed tests cover:
- strobes tied together, including the state of the downstream copy;
- a clear that arrives in the middle of a byte;
- a clear that collides with a shift;
- the high-impedance state on the pins.

// File: rtl/slr_pkg.sv
package slr_pkg;
  // Strobes from the control to the datapath, one system clock wide
  typedef struct packed {
    logic shiftPulse;
    logic latchPulse;
    logic clearNow;
    logic serBit;
  } slr_strobe_t;

  localparam int SYNC_BITS = 4;
  localparam int IDX_SER   = 0;
  localparam int IDX_SHIFT = 1;
  localparam int IDX_LATCH = 2;
  localparam int IDX_CLEAR = 3;
endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[LAST];
endmodule

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serIn,
  input  logic        shiftStrb,
  input  logic        latchStrb,
  input  logic        clearN,
  output slr_strobe_t strb
);
  // The clear input idles high, so its synchronizer also resets high
  localparam logic [SYNC_BITS-1:0] SYNC_RST = SYNC_BITS'(1) << IDX_CLEAR;

  logic [SYNC_BITS-1:0] rawIn;
  logic [SYNC_BITS-1:0] syncIn;
  logic shiftPrev;
  logic latchPrev;

  always_comb begin
    rawIn            = '0;
    rawIn[IDX_SER]   = serIn;
    rawIn[IDX_SHIFT] = shiftStrb;
    rawIn[IDX_LATCH] = latchStrb;
    rawIn[IDX_CLEAR] = clearN;
  end

  slr_sync #(
    .WIDTH  (SYNC_BITS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftPrev <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      shiftPrev <= syncIn[IDX_SHIFT];
      latchPrev <= syncIn[IDX_LATCH];
    end
  end

  always_comb begin
    strb.shiftPulse = syncIn[IDX_SHIFT] & ~shiftPrev;
    strb.latchPulse = syncIn[IDX_LATCH] & ~latchPrev;
    strb.clearNow   = ~syncIn[IDX_CLEAR];
    strb.serBit     = syncIn[IDX_SER];
  end
endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  slr_strobe_t      strb,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] holdQ
);
  localparam int TOP = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
    end else if (strb.clearNow) begin
      shiftQ <= '0;
    end else if (strb.shiftPulse) begin
      shiftQ <= {shiftQ[TOP-1:0], strb.serBit};
    end
  end

  // The holding register samples the shift stage before this cycle's update
  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ <= '0;
    end else if (strb.latchPulse) begin
      holdQ <= shiftQ;
    end
  end
endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serIn,
  input  logic             shiftStrb,
  input  logic             latchStrb,
  input  logic             clearN,
  input  logic             oeN,
  output logic [WIDTH-1:0] parData,
  output logic [WIDTH-1:0] parDriveEn,
  output logic [WIDTH-1:0] parPins,
  output logic             cascadeOut
);
  import slr_pkg::*;

  slr_strobe_t      strb;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] holdQ;

  slr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serIn    (serIn),
    .shiftStrb(shiftStrb),
    .latchStrb(latchStrb),
    .clearN   (clearN),
    .strb     (strb)
  );

  slr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .shiftQ(shiftQ),
    .holdQ (holdQ)
  );

  assign parData    = holdQ;
  assign cascadeOut = shiftQ[WIDTH-1];
  assign parDriveEn = {WIDTH{~oeN}};

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    assign parPins[b] = parDriveEn[b] ? holdQ[b] : 1'bz;
  end
endmodule

// File: rtl/serial_latch_reg_chk.sv
module serial_latch_reg_chk
  import slr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input slr_strobe_t      strb,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] holdQ
);
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (strb.shiftPulse && !strb.clearNow) |=> shiftQ == {$past(shiftQ[WIDTH-2:0]), $past(strb.serBit)}); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.shiftPulse |=> !strb.shiftPulse); // R3

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    strb.clearNow |=> shiftQ == '0); // R4

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !strb.latchPulse |=> $stable(holdQ)); // R5

  AST_LATCH_PRIOR: assert property (@(posedge clk) disable iff (rst)
    strb.latchPulse |=> holdQ == $past(shiftQ)); // R6
endmodule

bind serial_latch_reg serial_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .strb  (strb),
  .shiftQ(shiftQ),
  .holdQ (holdQ)
);

// File: tb/test_serial_latch_reg.sv
module test_serial_latch_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 6;
  // {byte shifted in, expected upstream parData, expected downstream parData}
  localparam logic [23:0] VEC [NVEC] = '{
    24'hA5_A5_00, 24'h3C_3C_A5, 24'hFF_FF_3C,
    24'h00_00_FF, 24'h81_81_00, 24'h6E_6E_81
  };

  logic clk = 0;
  logic rst = 1;
  logic serIn = 0, shiftStrb = 0, latchStrb = 0, clearN = 1, oeN = 0;
  logic [W-1:0] parData, parDriveEn, parPins, parDataB, parDriveEnB, parPinsB;
  logic cascadeOut, cascadeOutB;
  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_reg i_serial_latch_reg (
    .clk(clk), .rst(rst), .serIn(serIn), .shiftStrb(shiftStrb),
    .latchStrb(latchStrb), .clearN(clearN), .oeN(oeN), .parData(parData),
    .parDriveEn(parDriveEn), .parPins(parPins), .cascadeOut(cascadeOut));

  serial_latch_reg i_serial_latch_reg_b (
    .clk(clk), .rst(rst), .serIn(cascadeOut), .shiftStrb(shiftStrb),
    .latchStrb(latchStrb), .clearN(clearN), .oeN(oeN), .parData(parDataB),
    .parDriveEn(parDriveEnB), .parPins(parPinsB), .cascadeOut(cascadeOutB));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic doShift, input logic doLatch, input logic bitIn);
    serIn = bitIn;
    waitN(1);
    shiftStrb = doShift;
    latchStrb = doLatch;
    waitN(4);
    shiftStrb = 0;
    latchStrb = 0;
    waitN(4);
  endtask

  task automatic shiftByte(input logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) strobe(1, 0, b[i]);
  endtask

  task automatic pulseClear();
    clearN = 0;
    waitN(4);
    clearN = 1;
    waitN(4);
  endtask

  initial begin
    waitN(3);
    rst = 0;
    waitN(1);
    check("R1 parData", parData, 0);
    check("R1 cascade", cascadeOut, 0);
    check("R7 driveEn", parDriveEn, 8'hFF);

    // Table: each byte ends upstream; the downstream copy holds the previous one
    for (int v = 0; v < NVEC; v++) begin
      shiftByte(VEC[v][23:16]);
      check("R5 hold before latch", parData, (v == 0) ? 8'h00 : VEC[v-1][15:8]);
      strobe(0, 1, 0);
      check("R2 upstream byte", parData, VEC[v][15:8]);
      check("R2 downstream byte", parDataB, VEC[v][7:0]);
      check("R2 cascade top bit", cascadeOut, VEC[v][23]);
    end

    // Shift a nibble without latching: the shift stage becomes EA, the hold stays 6E
    strobe(1, 0, 1); strobe(1, 0, 0); strobe(1, 0, 1); strobe(1, 0, 0);
    check("R5 hold unchanged", parData, 8'h6E);

    // Tied strobes: hold gets EA, shift becomes D5; downstream hold 16, shift 2D
    strobe(1, 1, 1);
    check("R6 tied upstream", parData, 8'hEA);
    check("R6 tied downstream", parDataB, 8'h16);

    // R8: a latch rise is driven here; hold must change only at the third edge
    latchStrb = 1;
    waitN(2);
    check("R8 no change after two edges", parData, 8'hEA);
    waitN(1);
    check("R8 change at third edge", parData, 8'hD5);
    check("R6 downstream after latch", parDataB, 8'h2D);
    waitN(2);
    check("R3 held strobe single action", parData, 8'hD5);
    latchStrb = 0;
    waitN(4);

    // Clear partway through a byte
    strobe(1, 0, 1); strobe(1, 0, 1); strobe(1, 0, 1);
    check("R2 cascade before clear", cascadeOut, 1);
    pulseClear();
    check("R4 cascade cleared", cascadeOut, 0);
    check("R5 hold survives clear", parData, 8'hD5);
    strobe(0, 1, 0);
    check("R4 cleared shift latched", parData, 8'h00);

    // Clear colliding with a shift: the clear must win
    strobe(1, 0, 1);
    serIn = 1;
    waitN(1);
    clearN = 0;
    shiftStrb = 1;
    waitN(4);
    shiftStrb = 0;
    clearN = 1;
    waitN(4);
    strobe(0, 1, 0);
    check("R4 clear beats shift", parData, 8'h00);
    check("R4 clear beats shift downstream", parDataB, 8'h00);

    // Output enable
    strobe(1, 0, 1);
    strobe(0, 1, 0);
    oeN = 1;
    #1;
    check("R7 driveEn off", parDriveEn, 8'h00);
    nCmp++;
    if (parPins !== 8'bzzzzzzzz) begin
      nBad++;
      $display("FAIL R7 hi-z: actual %b expected zzzzzzzz", parPins);
    end
    check("R7 parData kept", parData, 8'h01);
    oeN = 0;
    #1;
    check("R7 pins driven", parPins, 8'h01);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule